// File: doc/BRIEF.md
# Servo Position Packet Decoder

This block sits behind a serial byte receiver and turns a stream of received bytes into position settings for eight servo channels. Each setting is carried by a two-byte packet. The lead byte has bit 7 set. It names the channel and supplies the top bit of the position. The trailing byte has bit 7 clear and supplies the lower seven position bits. Each completed packet writes an 8-bit value into an eight-entry position store. A pulse generator reads that store through a combinational read port.

The block also records which channels have received at least one complete packet. It raises a servo power-enable output once every channel has been loaded. After that point the enable stays high and the loaded-channel mask stops changing, while position updates continue to be written.

Top module: `servo_pkt_decoder`

## Requirements
- R1: A synchronous active-high reset clears all eight positions to zero, clears the loaded-channel mask, drops power-enable and forgets any pending lead byte.
- R2: A strobed byte with bit 7 = 1 is a lead byte. Bits 3:1 give the channel number (0 to 7) and bit 0 gives position bit 7. It arms a pending state. Bits 6:4 carry no meaning.
- R3: A strobed byte with bit 7 = 0, arriving while a lead byte is pending, completes the packet. The position {lead bit 0, trailing bits 6:0} is stored for the pending channel. The new value is visible on the read port from the clock edge that samples the trailing byte.
- R4: A trailing byte that arrives with no lead byte pending is dropped. It leaves positions, mask and power-enable unchanged.
- R5: Completing a packet clears the pending state, so a second trailing byte without a new lead byte is dropped.
- R6: A new lead byte replaces the channel and top bit of any pending lead byte. The earlier channel is left untouched.
- R7: While power-enable is low, each completed packet sets the mask bit whose index equals the channel number. Mask bits only clear on reset.
- R8: Power-enable goes high at the same clock edge at which the mask becomes all ones, and never while any mask bit is clear.
- R9: Once high, power-enable stays high until reset and the mask holds its value. Position writes continue.
- R10: The read port returns the stored position of the addressed channel combinationally. A read of a channel in the cycle its trailing byte is strobed returns the old value.
- R11: With the strobe low, the byte input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe, at most one byte per cycle |
| rx_data | input | 8 | Received byte |
| rd_addr | input | 3 | Channel selected on the read port |
| rd_data | output | 8 | Stored position of the selected channel |
| valid_mask | output | 8 | Bit n set once channel n has received a complete packet |
| power_en | output | 1 | Servo power enable |

## Verification
Two functions can fall in one cycle: a trailing byte writes a channel while the read port is addressing that same channel. The bench provokes this on several channels, including the channel whose packet completes the mask. That same edge also raises power-enable, so the final packet lands a write, a mask update and the power rise together. The read port is sampled before the edge and must show the old value. It is sampled again after the edge and must show the new one, and power-enable must rise exactly at that edge.

// File: rtl/servo_pkt_decoder.sv
module servo_pkt_decoder #(
  parameter int CH_W  = 3,
  parameter int POS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic [CH_W-1:0]       rd_addr,
  output logic [POS_W-1:0]      rd_data,
  output logic [(1<<CH_W)-1:0]  valid_mask,
  output logic                  power_en
);
  localparam int NCH = 1 << CH_W;

  logic [POS_W-1:0] pos [NCH];
  logic             pending;
  logic [CH_W-1:0]  pend_ch;
  logic             pend_msb;
  logic [NCH-1:0]   ch_bit;
  logic [NCH-1:0]   next_mask;

  wire lead_in  = rx_valid &  rx_data[7];
  wire accept   = rx_valid & ~rx_data[7] & pending;

  assign ch_bit    = NCH'(1) << pend_ch;
  assign next_mask = valid_mask | ch_bit;
  assign rd_data   = pos[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      pend_ch    <= '0;
      pend_msb   <= 1'b0;
      valid_mask <= '0;
      power_en   <= 1'b0;
      for (int i = 0; i < NCH; i++) pos[i] <= '0;
    end else if (lead_in) begin
      pending  <= 1'b1;
      pend_ch  <= rx_data[CH_W:1];
      pend_msb <= rx_data[0];
    end else if (accept) begin
      pending      <= 1'b0;
      pos[pend_ch] <= {pend_msb, rx_data[6:0]};
      if (!power_en) begin
        valid_mask <= next_mask;
        if (&next_mask) power_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/servo_pkt_decoder_chk.sv
module servo_pkt_decoder_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           rx_valid,
  input logic [7:0]     rx_data,
  input logic           pending,
  input logic [NCH-1:0] valid_mask,
  input logic           power_en
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (valid_mask == '0 && !power_en && !pending));

  assert_lead_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_data[7]) |=> pending);

  assert_orphan_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_data[7] && !pending) |=> ($stable(valid_mask) && $stable(power_en)));

  assert_pending_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_data[7] && pending) |=> !pending);

  assert_mask_monotone_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((valid_mask & $past(valid_mask)) == $past(valid_mask)));

  assert_power_gate_R8: assert property (@(posedge clk) disable iff (rst)
    power_en |-> (&valid_mask));

  assert_power_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    power_en |=> (power_en && $stable(valid_mask)));

  assert_idle_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(pending) && $stable(valid_mask)));
endmodule

bind servo_pkt_decoder servo_pkt_decoder_chk #(.NCH(1 << CH_W)) chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
  .pending(pending), .valid_mask(valid_mask), .power_en(power_en)
);

// File: tb/servo_pkt_decoder_test.sv
`timescale 1ns/1ps
module servo_pkt_decoder_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [7:0] valid_mask;
  logic       power_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int m_pos [8];
  int m_mask, m_pow, m_pend, m_ch, m_msb;

  always #2 clk = ~clk;

  servo_pkt_decoder uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .valid_mask(valid_mask), .power_en(power_en)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_pos[i] = 0;
    m_mask = 0; m_pow = 0; m_pend = 0; m_ch = 0; m_msb = 0;
  endtask

  task automatic model_step(bit v, int b);
    if (!v) return;
    if (b >= 128) begin
      m_pend = 1; m_ch = (b / 2) % 8; m_msb = b % 2;
    end else if (m_pend == 1) begin
      m_pend = 0;
      m_pos[m_ch] = m_msb * 128 + b;
      if (m_pow == 0) begin
        m_mask = m_mask | (1 << m_ch);
        if (m_mask == 255) m_pow = 1;
      end
    end
  endtask

  task automatic step(string tag, bit v, logic [7:0] b, logic [2:0] ra);
    @(negedge clk);
    rx_valid = v; rx_data = b; rd_addr = ra;
    #0.5;
    chk("R10", "read before edge", int'(rd_data), m_pos[ra]);
    @(posedge clk);
    model_step(v, int'(b));
    @(negedge clk);
    chk(tag, "read after edge", int'(rd_data), m_pos[ra]);
    chk(tag, "valid mask", int'(valid_mask), m_mask);
    chk(tag, "power enable", int'(power_en), m_pow);
    rx_valid = 0;
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      #0.5;
      chk(tag, "sweep read", int'(rd_data), m_pos[i]);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    sweep("R1");
    chk("R1", "mask after reset", int'(valid_mask), 0);
    chk("R1", "power after reset", int'(power_en), 0);
    rst = 0;

    step("R4", 1, 8'h55, 3'd0);
    step("R11", 0, 8'h87, 3'd3);
    step("R11", 0, 8'h22, 3'd3);
    step("R2", 1, 8'h87, 3'd3);
    step("R3", 1, 8'h22, 3'd3);
    step("R5", 1, 8'h11, 3'd3);
    step("R6", 1, 8'h8A, 3'd5);
    step("R6", 1, 8'h83, 3'd1);
    step("R6", 1, 8'h7F, 3'd1);
    step("R6", 0, 8'h00, 3'd5);
    step("R2", 1, 8'hF5, 3'd2);
    step("R7", 1, 8'h40, 3'd2);
    step("R7", 1, 8'h80, 3'd0);
    step("R7", 1, 8'h00, 3'd0);
    step("R7", 1, 8'h89, 3'd4);
    step("R7", 1, 8'h33, 3'd4);
    step("R7", 1, 8'h8C, 3'd6);
    step("R7", 1, 8'h0F, 3'd6);
    step("R7", 1, 8'h8F, 3'd7);
    step("R7", 1, 8'h7E, 3'd7);
    step("R8", 1, 8'h8B, 3'd5);
    step("R8", 1, 8'h01, 3'd5);
    sweep("R3");
    step("R9", 1, 8'h87, 3'd3);
    step("R9", 1, 8'h05, 3'd3);
    step("R9", 1, 8'h66, 3'd3);
    step("R9", 1, 8'h80, 3'd0);
    step("R9", 1, 8'h7B, 3'd0);
    sweep("R9");

    @(negedge clk);
    rst = 1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
    sweep("R1");
    chk("R1", "mask after second reset", int'(valid_mask), 0);
    chk("R1", "power after second reset", int'(power_en), 0);
    step("R1", 1, 8'h12, 3'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule